// File: doc/BRIEF.md
# Guarded Control Register Write Sequencer

This block holds an 8-bit control register. The register has two volatile write-enable latches and six nonvolatile configuration bits: two power-on delay select bits, two voltage-fail status bits and two block-lock bits. It sits behind a serial byte front end that has already decoded start, stop, byte strobes and the register address. It follows each transaction, acknowledges the bytes it accepts, and answers single-byte reads with the register image.

The nonvolatile bits change only through a fixed three-write unlock. The first write sets the primary latch. The second write sets the secondary latch. The third write is a masked data byte, and it commits only when the write-protect input is low. A commit starts a timed programming interval. During that interval the busy flag is high and write bytes are refused. One pattern of the third byte re-arms the secondary latch instead of committing. A second data byte in the same write transaction aborts that transaction. The configuration outputs drive a downstream reset timer and voltage-fail flag logic.

Top module: `cr_guard`

## Requirements
- R1: While rst_ni is low, the nonvolatile fields take the parameter NV_INIT (default: delay select 3, fail status 0, lock 2, image 0x91). Both latches clear and busy_o is low.
- R2: A write of 0x02 while the primary latch is clear sets the primary latch at once, with no busy interval. The primary latch is image bit 1.
- R3: A write of exactly 0x06 while only the primary latch is set sets the secondary latch, which is image bit 2. With the primary latch clear, 0x06 has no effect.
- R4: With both latches set and write protect low, a byte whose bits [2:1] are 01 commits. Delay select becomes {bit7,bit0}, fail status becomes {bit6,bit5} and lock becomes {bit4,bit3}. The commit clears the secondary latch and keeps the primary latch.
- R5: With both latches set, a byte whose bits [2:1] are 11 leaves the secondary latch set and all six nonvolatile bits unchanged.
- R6: A byte that fits no pattern for the current step leaves the nonvolatile bits unchanged and clears the secondary latch.
- R7: After a commit, busy_o stays high for exactly WR_CYCLES cycles. A write byte that arrives while busy is not acknowledged and has no effect.
- R8: A second data byte in one write transaction is not acknowledged and aborts the write. The first byte then has no effect.
- R9: While wp_i is high, a commit-pattern byte changes no nonvolatile bit, starts no busy interval, and still clears the secondary latch. The latch writes keep working.
- R10: A read returns one byte on rd_data_o with rd_valid_o, laid out as {dly[1], fail[1], fail[0], lock[1], lock[0], secondary, primary, dly[0]}. A further byte request in the same read gets no rd_valid_o. A read leaves the latches unchanged.
- R11: The write sequence 0x02, 0x06, 0x02 clears all six nonvolatile bits.
- R12: ack_o pulses for one cycle, the cycle after an accepted first write byte.
- R13: A transaction whose start arrives with addr_match_i low is ignored and not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start condition strobe |
| stop_i | input | 1 | Stop condition strobe |
| byte_valid_i | input | 1 | Byte strobe (write data, or read request) |
| byte_i | input | 8 | Write data byte |
| addr_match_i | input | 1 | Control register addressed, sampled with start_i |
| rnw_i | input | 1 | Read (1) or write (0), sampled with start_i |
| wp_i | input | 1 | Write protect for the nonvolatile bits |
| ack_o | output | 1 | Acknowledge for an accepted write byte |
| rd_valid_o | output | 1 | Read byte valid pulse |
| rd_data_o | output | 8 | Read register image |
| busy_o | output | 1 | Nonvolatile programming interval in progress |
| wel_o | output | 1 | Primary write-enable latch |
| rwel_o | output | 1 | Secondary write-enable latch |
| pup_o | output | 2 | Power-on delay select |
| vfail_o | output | 2 | Voltage-fail status bits |
| blk_o | output | 2 | Block-lock bits |

## Verification
The hardest case to reach is the state where both latches are set and a non-commit byte arrives. This has to be tested in several forms: the re-arm pattern, a mismatching pattern, a commit under write protect, and a transaction aborted by a second byte. Each form needs a fresh re-arm through 0x06 first. The stimulus chains these cases so that every one starts from both latches set. It reads the register image back between them to confirm that the secondary latch and the fields held exactly the values expected. Refusal during the busy interval is reached by sending 0x06 right after a commit, when it would otherwise set the secondary latch.

// File: rtl/cr_guard_pkg.sv
package cr_guard_pkg;

  typedef struct packed {
    logic [1:0] pup;
    logic [1:0] vfail;
    logic [1:0] blk;
  } nv_cfg_t;

  typedef enum logic [1:0] {
    X_IDLE,
    X_WR_FIRST,
    X_WR_HELD,
    X_RD
  } xact_st_e;

  localparam logic [7:0] CMD_WEL  = 8'h02;
  localparam logic [7:0] CMD_RWEL = 8'h06;

  function automatic logic [7:0] cr_image(nv_cfg_t nv, logic wel, logic rwel);
    return {nv.pup[1], nv.vfail[1], nv.vfail[0], nv.blk[1], nv.blk[0],
            rwel, wel, nv.pup[0]};
  endfunction

endpackage

// File: rtl/cr_guard_xact.sv
module cr_guard_xact
  import cr_guard_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       addr_match_i,
  input  logic       rnw_i,
  input  logic       busy_i,
  input  logic [7:0] image_i,
  output logic       ack_o,
  output logic       exec_o,
  output logic [7:0] exec_data_o,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o
);

  xact_st_e   state_q;
  logic [7:0] held_q;
  logic       ack_q, exec_q, rdv_q;
  logic [7:0] rdd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= X_IDLE;
      held_q  <= '0;
      ack_q   <= 1'b0;
      exec_q  <= 1'b0;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
    end else begin
      ack_q  <= 1'b0;
      exec_q <= 1'b0;
      rdv_q  <= 1'b0;
      if (start_i) begin
        if (!addr_match_i)  state_q <= X_IDLE;
        else if (rnw_i)     state_q <= X_RD;
        else                state_q <= X_WR_FIRST;
      end else if (stop_i) begin
        if (state_q == X_WR_HELD) exec_q <= 1'b1;
        state_q <= X_IDLE;
      end else if (byte_valid_i) begin
        unique case (state_q)
          X_WR_FIRST: begin
            if (!busy_i) begin
              held_q  <= byte_i;
              ack_q   <= 1'b1;
              state_q <= X_WR_HELD;
            end else begin
              state_q <= X_IDLE;
            end
          end
          X_WR_HELD: state_q <= X_IDLE;  // second byte: abort, no ack
          X_RD: begin
            rdv_q   <= 1'b1;
            rdd_q   <= image_i;
            state_q <= X_IDLE;          // one byte per read
          end
          default: state_q <= X_IDLE;
        endcase
      end
    end
  end

  assign ack_o       = ack_q;
  assign exec_o      = exec_q;
  assign exec_data_o = held_q;
  assign rd_valid_o  = rdv_q;
  assign rd_data_o   = rdd_q;

  a_r8_abort_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == X_WR_HELD && byte_valid_i && !start_i && !stop_i) |=> (!ack_o && !exec_o));

  a_r10_single_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  a_r7_busy_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && byte_valid_i) |=> !ack_o);

  a_r12_ack_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(byte_valid_i));

endmodule

// File: rtl/cr_guard_seq.sv
module cr_guard_seq
  import cr_guard_pkg::*;
#(
  parameter nv_cfg_t NV_INIT = 6'b11_00_10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       exec_i,
  input  logic [7:0] data_i,
  input  logic       wp_i,
  output logic       commit_o,
  output logic       wel_o,
  output logic       rwel_o,
  output nv_cfg_t    nv_o
);

  nv_cfg_t nv_q, nv_d;
  logic    wel_q, wel_d, rwel_q, rwel_d, commit;

  always_comb begin
    nv_d   = nv_q;
    wel_d  = wel_q;
    rwel_d = rwel_q;
    commit = 1'b0;
    if (exec_i) begin
      if (wel_q && rwel_q) begin
        unique case (data_i[2:1])
          2'b01: begin
            rwel_d = 1'b0;
            if (!wp_i) begin
              commit   = 1'b1;
              nv_d.pup   = {data_i[7], data_i[0]};
              nv_d.vfail = {data_i[6], data_i[5]};
              nv_d.blk   = {data_i[4], data_i[3]};
            end
          end
          2'b11:   rwel_d = 1'b1;  // re-arm only
          default: rwel_d = 1'b0;
        endcase
      end else if (wel_q) begin
        rwel_d = (data_i == CMD_RWEL);
      end else if (data_i == CMD_WEL) begin
        wel_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_q   <= NV_INIT;
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
    end else begin
      nv_q   <= nv_d;
      wel_q  <= wel_d;
      rwel_q <= rwel_d;
    end
  end

  assign commit_o = commit;
  assign wel_o    = wel_q;
  assign rwel_o   = rwel_q;
  assign nv_o     = nv_q;

  a_r9_wp_holds_nv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |=> $stable(nv_q));

  a_r4_commit_clears_rwel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (!rwel_q && wel_q));

  a_r3_rwel_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rwel_q |-> wel_q);

  a_r6_no_exec_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> ($stable(nv_q) && $stable(rwel_q)));

endmodule

// File: rtl/cr_guard_timer.sv
module cr_guard_timer #(
  parameter int unsigned WR_CYCLES = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);

  localparam int unsigned CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= CW'(WR_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  a_r7_busy_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o);

  a_r7_no_load_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);

endmodule

// File: rtl/cr_guard.sv
module cr_guard
  import cr_guard_pkg::*;
#(
  parameter nv_cfg_t     NV_INIT   = 6'b11_00_10,
  parameter int unsigned WR_CYCLES = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       addr_match_i,
  input  logic       rnw_i,
  input  logic       wp_i,
  output logic       ack_o,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o,
  output logic       busy_o,
  output logic       wel_o,
  output logic       rwel_o,
  output logic [1:0] pup_o,
  output logic [1:0] vfail_o,
  output logic [1:0] blk_o
);

  logic       exec, commit, busy, wel, rwel;
  logic [7:0] exec_data, image;
  nv_cfg_t    nv;

  assign image = cr_image(nv, wel, rwel);

  cr_guard_xact u_xact (
    .clk_i, .rst_ni, .start_i, .stop_i, .byte_valid_i, .byte_i,
    .addr_match_i, .rnw_i,
    .busy_i      (busy),
    .image_i     (image),
    .ack_o,
    .exec_o      (exec),
    .exec_data_o (exec_data),
    .rd_valid_o,
    .rd_data_o
  );

  cr_guard_seq #(.NV_INIT(NV_INIT)) u_seq (
    .clk_i, .rst_ni,
    .exec_i   (exec),
    .data_i   (exec_data),
    .wp_i,
    .commit_o (commit),
    .wel_o    (wel),
    .rwel_o   (rwel),
    .nv_o     (nv)
  );

  cr_guard_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk_i, .rst_ni,
    .load_i (commit),
    .busy_o (busy)
  );

  assign busy_o  = busy;
  assign wel_o   = wel;
  assign rwel_o  = rwel;
  assign pup_o   = nv.pup;
  assign vfail_o = nv.vfail;
  assign blk_o   = nv.blk;

endmodule

// File: tb/cr_guard_tb_top.sv
module cr_guard_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WR_CYC     = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0, bv = 1'b0, am = 1'b0, rnw = 1'b0, wp = 1'b0;
  logic [7:0] bd = '0;
  logic       ack, rdv, busy, wel, rwel;
  logic [7:0] rdd;
  logic [1:0] pup, vfail, blk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cr_guard #(.WR_CYCLES(WR_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .byte_valid_i(bv), .byte_i(bd), .addr_match_i(am), .rnw_i(rnw), .wp_i(wp),
    .ack_o(ack), .rd_valid_o(rdv), .rd_data_o(rdd), .busy_o(busy),
    .wel_o(wel), .rwel_o(rwel), .pup_o(pup), .vfail_o(vfail), .blk_o(blk)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic match, output logic a);
    @(negedge clk) start = 1'b1; am = match; rnw = 1'b0;
    @(negedge clk) start = 1'b0; bv = 1'b1; bd = d;
    @(negedge clk) bv = 1'b0; a = ack; stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(output logic [7:0] d, output logic v1, output logic v2);
    @(negedge clk) start = 1'b1; am = 1'b1; rnw = 1'b1;
    @(negedge clk) start = 1'b0; bv = 1'b1;
    @(negedge clk) bv = 1'b0; v1 = rdv; d = rdd; bv = 1'b1;
    @(negedge clk) bv = 1'b0; v2 = rdv; stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  task automatic expect_image(input string req, input logic [7:0] exp);
    logic [7:0] d; logic v1, v2;
    rd(d, v1, v2);
    chk(req, v1, 1);
    chk(req, d, exp);
  endtask

  task automatic wait_busy(input string req, input int exp_len);
    int cnt = 0;
    for (int i = 0; i < exp_len + 10; i++) begin
      if (busy) cnt++;
      @(negedge clk);
    end
    chk(req, cnt, exp_len);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 latches", {rwel, wel}, 0);
    chk("R1 fields", {pup, vfail, blk}, 6'b11_00_10);
    expect_image("R1 image", 8'h91);
  endtask

  task automatic t_rwel_without_wel;
    logic a;
    wr(8'h06, 1'b1, a);
    chk("R12 ack", a, 1);
    expect_image("R3 no effect without primary", 8'h91);
  endtask

  task automatic t_set_wel;
    logic a;
    wr(8'h02, 1'b1, a);
    chk("R2 busy", busy, 0);
    expect_image("R2 primary set", 8'h93);
  endtask

  task automatic t_read_one_byte;
    logic [7:0] d; logic v1, v2;
    rd(d, v1, v2);
    chk("R10 first byte", v1, 1);
    chk("R10 second request", v2, 0);
    chk("R10 latches kept", {rwel, wel}, 2'b01);
  endtask

  task automatic t_rearm_and_commit;
    logic a;
    wr(8'h06, 1'b1, a);
    expect_image("R3 secondary set", 8'h97);
    wr(8'h6E, 1'b1, a);
    expect_image("R5 re-arm keeps fields", 8'h97);
    wr(8'h6A, 1'b1, a);
    chk("R12 commit ack", a, 1);
    chk("R4 fields", {pup, vfail, blk}, 6'b00_11_01);
    chk("R4 latches", {rwel, wel}, 2'b01);
    wr(8'h06, 1'b1, a);
    chk("R7 no ack while busy", a, 0);
    chk("R7 write ignored while busy", rwel, 0);
    wait_busy("R7 busy length", WR_CYC - 5);
    expect_image("R4 image", 8'h6A);
  endtask

  task automatic t_busy_length;
    logic a;
    wr(8'h06, 1'b1, a);
    wr(8'h6A, 1'b1, a);
    wait_busy("R7 busy length", WR_CYC);
  endtask

  task automatic t_write_protect;
    logic a;
    wp = 1'b1;
    wr(8'h06, 1'b1, a);
    expect_image("R9 latch works under protect", 8'h6E);
    wr(8'h02, 1'b1, a);
    chk("R9 no busy", busy, 0);
    expect_image("R9 fields kept", 8'h6A);
    wp = 1'b0;
  endtask

  task automatic t_mismatch;
    logic a;
    wr(8'h06, 1'b1, a);
    wr(8'h55, 1'b1, a);
    expect_image("R6 mismatch clears secondary", 8'h6A);
  endtask

  task automatic t_abort;
    logic a1, a2;
    logic a;
    wr(8'h06, 1'b1, a);
    @(negedge clk) start = 1'b1; am = 1'b1; rnw = 1'b0;
    @(negedge clk) start = 1'b0; bv = 1'b1; bd = 8'h02;
    @(negedge clk) a1 = ack; bd = 8'hFF;
    @(negedge clk) bv = 1'b0; a2 = ack; stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    @(negedge clk);
    chk("R12 first byte ack", a1, 1);
    chk("R8 second byte no ack", a2, 0);
    chk("R8 no busy", busy, 0);
    expect_image("R8 aborted write", 8'h6E);
  endtask

  task automatic t_clear_all;
    logic a;
    wr(8'h02, 1'b1, a);
    expect_image("R11 fields cleared", 8'h02);
    wait_busy("R11 busy", WR_CYC - 5);
  endtask

  task automatic t_addr_miss;
    logic a;
    wr(8'h06, 1'b0, a);
    chk("R13 no ack", a, 0);
    expect_image("R13 ignored", 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rwel_without_wel();
    t_set_wel();
    t_read_one_byte();
    t_rearm_and_commit();
    t_busy_length();
    t_write_protect();
    t_mismatch();
    t_abort();
    t_clear_all();
    t_addr_miss();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule